// File: doc/BRIEF.md
# Dual-Register Peripheral Access Decoder

This block sits between the I/O bus of a 4-bit core and up to sixteen peripheral modules. Each bus cycle carries a module number, a 4-bit write nibble and separate one-clock read and write strobes. The block turns that cycle into a single strobe for the register the access actually lands on. Three kinds of target exist:

- the module's primary register, which plain accesses reach;
- its auxiliary register, reached by arming a switching module beforehand;
- for extended modules, one of sixteen subport registers, picked through an index held in the auxiliary register.

Registers wider than a nibble are moved by back-to-back accesses to the same target. The block reports which nibble of such a run the current access is.

All outputs are combinational from the present bus cycle and the stored selection state. That state is the armed switch, the per-module subport indexes and the nibble run, and it updates on the clock edge that ends the cycle. The bus side has no back-pressure. Every cycle with a read or write strobe is taken in the cycle it is shown, and the peripheral must consume its strobe in that same cycle.

Top module: `ioreg_decoder`

## Requirements
- R1: Reset clears the armed switch, sets every stored subport index to 0 and ends any nibble run. With no access during reset, all strobes are low.
- R2: An access to a non-extended module that is not armed raises bit `m` of `prim_stb` in the same cycle, where `m` is `bus_addr`.
- R3: A write to the switch address (`SW_ADDR`, default 15) arms module `bus_wdata`, and a later write there replaces the armed module. A read of the switch address leaves the armed module unchanged. No strobe is raised in either case.
- R4: The next access to the armed module raises its `aux_stb` bit instead of its usual strobe and disarms the switch. The access after that falls back to normal selection.
- R5: An access to any other module (not the switch address) while armed gets normal selection and disarms the switch.
- R6: In an extended module (`EXT_MASK` bit set, default modules 0 and 1), a write to the auxiliary register stores `bus_wdata` as that module's own subport index. Unarmed accesses to such a module raise its `sub_stb` bit with `sub_idx` set to the stored index, and never its `prim_stb` bit. `sub_idx` is 0 when no subport strobe is raised.
- R7: `nib_idx` counts how many accesses to the same register came directly before this one, modulo 4. The register is identified by kind, module and subport index. It is 0 on the first access after a change of register. Idle cycles and switch accesses do not break a run.
- R8: A cycle with neither strobe raises no strobe. If both read and write are high, the cycle is a write. `acc_wr` is high exactly when a strobe is raised for a write.
- R9: At most one bit across `prim_stb`, `aux_stb` and `sub_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Module number of the current access |
| bus_wdata | input | 4 | Write nibble |
| bus_rd | input | 1 | Read strobe, one clock |
| bus_wr | input | 1 | Write strobe, one clock |
| prim_stb | output | 16 | Primary register strobe, one bit per module |
| aux_stb | output | 16 | Auxiliary register strobe, one bit per module |
| sub_stb | output | 16 | Subport register strobe, one bit per module |
| sub_idx | output | 4 | Subport index for the raised subport strobe |
| nib_idx | output | 2 | Nibble position inside a multi-access run |
| acc_wr | output | 1 | Raised strobe belongs to a write |

## Verification
The bench builds the block with its defaults: sixteen modules, the switch at address 15, modules 0 and 1 extended, and a 2-bit nibble counter. With these values all three strobe kinds can be reached from one access stream, and two extended modules can be shown to keep separate subport indexes. The short counter also brings a nibble-run wraparound within five accesses. The vector table walks arming, one-shot fallback, disarming by another module, the switch read and double-strobe cycles. Directed steps then show that reset drops an armed switch and zeroes the stored indexes.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_PRIM = 2'd1,
    KIND_AUX  = 2'd2,
    KIND_SUB  = 2'd3
  } tgt_kind_e;
endpackage

// File: rtl/ioreg_arm.sv
// One-shot auxiliary selection: armed by a switch write, dropped by any
// peripheral access.
module ioreg_arm #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_mod,
  input  logic          periph_acc,
  output logic          armed,
  output logic [AW-1:0] arm_mod
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      arm_mod <= '0;
    end else if (sw_wr) begin
      armed   <= 1'b1;
      arm_mod <= sw_mod;
    end else if (periph_acc) begin
      armed   <= 1'b0;
    end
  end
endmodule

// File: rtl/ioreg_subbank.sv
// Per-module subport index store; only extended modules get a register.
module ioreg_subbank #(
  parameter int               N_MOD    = 16,
  parameter int               DW       = 4,
  parameter logic [N_MOD-1:0] EXT_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_MOD-1:0]    we,
  input  logic [DW-1:0]       wdata,
  output logic [N_MOD*DW-1:0] idx_flat
);
  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    if (EXT_MASK[i]) begin : g_ext
      logic [DW-1:0] idx_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (we[i]) idx_q <= wdata;
      end
      assign idx_flat[i*DW +: DW] = idx_q;
    end else begin : g_plain
      assign idx_flat[i*DW +: DW] = '0;
    end
  end
endmodule

// File: rtl/ioreg_nibtrack.sv
// Tracks runs of consecutive accesses to one register.
module ioreg_nibtrack #(
  parameter int AW    = 4,
  parameter int DW    = 4,
  parameter int NIB_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc,
  input  ioreg_pkg::tgt_kind_e  kind,
  input  logic [AW-1:0]         mod,
  input  logic [DW-1:0]         sub,
  output logic [NIB_W-1:0]      nib
);
  localparam int KW = 2 + AW + DW;

  logic             last_vld;
  logic [KW-1:0]    last_key;
  logic [NIB_W-1:0] last_nib;
  logic [KW-1:0]    cur_key;
  logic             same;

  assign cur_key = {kind, mod, sub};
  assign same    = last_vld && (last_key == cur_key);
  assign nib     = same ? last_nib + 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld <= 1'b0;
      last_key <= '0;
      last_nib <= '0;
    end else if (acc) begin
      last_vld <= 1'b1;
      last_key <= cur_key;
      last_nib <= nib;
    end
  end
endmodule

// File: rtl/ioreg_decoder.sv
module ioreg_decoder #(
  parameter int                       N_MOD    = 16,
  parameter int                       DW       = 4,
  parameter int                       NIB_W    = 2,
  parameter int                       SW_ADDR  = 15,
  parameter logic [N_MOD-1:0]         EXT_MASK = 16'h0003,
  localparam int                      AW       = $clog2(N_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [N_MOD-1:0]  prim_stb,
  output logic [N_MOD-1:0]  aux_stb,
  output logic [N_MOD-1:0]  sub_stb,
  output logic [DW-1:0]     sub_idx,
  output logic [NIB_W-1:0]  nib_idx,
  output logic              acc_wr
);
  import ioreg_pkg::*;

  localparam logic [AW-1:0] SW_A = AW'(SW_ADDR);

  logic                access, is_sw, periph_acc, sw_wr;
  logic                armed, aux_hit, is_ext;
  logic [AW-1:0]       arm_mod;
  logic [N_MOD-1:0]    sub_we;
  logic [N_MOD*DW-1:0] idx_flat;
  logic [DW-1:0]       cur_sub;
  tgt_kind_e           kind;

  assign access     = bus_rd | bus_wr;
  assign is_sw      = (bus_addr == SW_A);
  assign periph_acc = access & ~is_sw;
  assign sw_wr      = bus_wr & is_sw;
  assign is_ext     = EXT_MASK[bus_addr];
  assign aux_hit    = periph_acc & armed & (arm_mod == bus_addr);

  always_comb begin
    if (!periph_acc)  kind = KIND_NONE;
    else if (aux_hit) kind = KIND_AUX;
    else if (is_ext)  kind = KIND_SUB;
    else              kind = KIND_PRIM;
  end

  ioreg_arm #(.AW(AW)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr      (sw_wr),
    .sw_mod     (bus_wdata[AW-1:0]),
    .periph_acc (periph_acc),
    .armed      (armed),
    .arm_mod    (arm_mod)
  );

  for (genvar i = 0; i < N_MOD; i++) begin : g_stb
    logic hit;
    assign hit         = (bus_addr == AW'(i));
    assign prim_stb[i] = hit && (kind == KIND_PRIM);
    assign aux_stb[i]  = hit && (kind == KIND_AUX);
    assign sub_stb[i]  = hit && (kind == KIND_SUB);
    assign sub_we[i]   = hit && (kind == KIND_AUX) && bus_wr && EXT_MASK[i];
  end

  ioreg_subbank #(.N_MOD(N_MOD), .DW(DW), .EXT_MASK(EXT_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (sub_we),
    .wdata    (bus_wdata),
    .idx_flat (idx_flat)
  );

  assign cur_sub = (kind == KIND_SUB) ? idx_flat[bus_addr*DW +: DW] : '0;
  assign sub_idx = cur_sub;
  assign acc_wr  = bus_wr && (kind != KIND_NONE);

  ioreg_nibtrack #(.AW(AW), .DW(DW), .NIB_W(NIB_W)) u_nib (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (periph_acc),
    .kind  (kind),
    .mod   (bus_addr),
    .sub   (cur_sub),
    .nib   (nib_idx)
  );
endmodule

// File: rtl/ioreg_decoder_chk.sv
module ioreg_decoder_chk #(
  parameter int               N_MOD    = 16,
  parameter int               SW_ADDR  = 15,
  parameter logic [N_MOD-1:0] EXT_MASK = '0,
  localparam int              AW       = $clog2(N_MOD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [N_MOD-1:0] prim_stb,
  input logic [N_MOD-1:0] aux_stb,
  input logic [N_MOD-1:0] sub_stb
);
  localparam logic [AW-1:0] SW_A = AW'(SW_ADDR);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prim_stb, aux_stb, sub_stb})); // R9
  AST_SWITCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr == SW_A) |-> ({prim_stb, aux_stb, sub_stb} == '0)); // R3
  AST_AUX_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|aux_stb) |=> (aux_stb == '0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> ({prim_stb, aux_stb, sub_stb} == '0)); // R8
  AST_EXT_NO_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((prim_stb & EXT_MASK) == '0) && ((sub_stb & ~EXT_MASK) == '0)); // R6
endmodule

bind ioreg_decoder ioreg_decoder_chk #(
  .N_MOD(N_MOD), .SW_ADDR(SW_ADDR), .EXT_MASK(EXT_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .prim_stb(prim_stb), .aux_stb(aux_stb), .sub_stb(sub_stb)
);

// File: tb/sim_ioreg_decoder.sv
`timescale 1ns/1ps
module sim_ioreg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] prim_stb, aux_stb, sub_stb;
  logic [3:0]  sub_idx;
  logic [1:0]  nib_idx;
  logic        acc_wr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ioreg_decoder u0 (.*);

  // kind: 0 none, 1 primary, 2 auxiliary, 3 subport
  typedef struct packed {
    logic rd; logic wr; logic [3:0] addr; logic [3:0] data;
    logic [1:0] kind; logic [3:0] mod; logic [3:0] sub; logic [1:0] nib; logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,4'd3 ,4'd5,2'd1,4'd3 ,4'd0,2'd0,4'd2}, // R2
    '{1'b1,1'b0,4'd3 ,4'd0,2'd1,4'd3 ,4'd0,2'd1,4'd7}, // R7
    '{1'b1,1'b0,4'd3 ,4'd0,2'd1,4'd3 ,4'd0,2'd2,4'd7},
    '{1'b0,1'b1,4'd4 ,4'd1,2'd1,4'd4 ,4'd0,2'd0,4'd7},
    '{1'b0,1'b1,4'd15,4'd4,2'd0,4'd0 ,4'd0,2'd0,4'd3}, // R3
    '{1'b1,1'b0,4'd4 ,4'd0,2'd2,4'd4 ,4'd0,2'd0,4'd3},
    '{1'b1,1'b0,4'd4 ,4'd0,2'd1,4'd4 ,4'd0,2'd0,4'd4}, // R4
    '{1'b0,1'b1,4'd15,4'd6,2'd0,4'd0 ,4'd0,2'd0,4'd3},
    '{1'b0,1'b1,4'd7 ,4'd2,2'd1,4'd7 ,4'd0,2'd0,4'd5}, // R5
    '{1'b1,1'b0,4'd6 ,4'd0,2'd1,4'd6 ,4'd0,2'd0,4'd5},
    '{1'b0,1'b1,4'd15,4'd0,2'd0,4'd0 ,4'd0,2'd0,4'd3},
    '{1'b0,1'b1,4'd0 ,4'd9,2'd2,4'd0 ,4'd0,2'd0,4'd6}, // R6
    '{1'b1,1'b0,4'd0 ,4'd0,2'd3,4'd0 ,4'd9,2'd0,4'd6},
    '{1'b0,1'b1,4'd0 ,4'd3,2'd3,4'd0 ,4'd9,2'd1,4'd7},
    '{1'b1,1'b0,4'd15,4'd0,2'd0,4'd0 ,4'd0,2'd0,4'd3},
    '{1'b1,1'b0,4'd0 ,4'd0,2'd3,4'd0 ,4'd9,2'd2,4'd7},
    '{1'b0,1'b1,4'd15,4'd1,2'd0,4'd0 ,4'd0,2'd0,4'd3},
    '{1'b0,1'b1,4'd1 ,4'd2,2'd2,4'd1 ,4'd0,2'd0,4'd6},
    '{1'b1,1'b0,4'd1 ,4'd0,2'd3,4'd1 ,4'd2,2'd0,4'd6},
    '{1'b1,1'b0,4'd0 ,4'd0,2'd3,4'd0 ,4'd9,2'd0,4'd6},
    '{1'b0,1'b0,4'd2 ,4'd0,2'd0,4'd0 ,4'd0,2'd0,4'd8}, // R8
    '{1'b1,1'b1,4'd5 ,4'd0,2'd1,4'd5 ,4'd0,2'd0,4'd8},
    '{1'b1,1'b0,4'd5 ,4'd0,2'd1,4'd5 ,4'd0,2'd1,4'd7},
    '{1'b1,1'b0,4'd5 ,4'd0,2'd1,4'd5 ,4'd0,2'd2,4'd7},
    '{1'b1,1'b0,4'd5 ,4'd0,2'd1,4'd5 ,4'd0,2'd3,4'd7},
    '{1'b1,1'b0,4'd5 ,4'd0,2'd1,4'd5 ,4'd0,2'd0,4'd7}, // wrap
    '{1'b0,1'b1,4'd15,4'd8,2'd0,4'd0 ,4'd0,2'd0,4'd3},
    '{1'b0,1'b1,4'd15,4'd9,2'd0,4'd0 ,4'd0,2'd0,4'd3},
    '{1'b1,1'b0,4'd8 ,4'd0,2'd1,4'd8 ,4'd0,2'd0,4'd5},
    '{1'b1,1'b0,4'd9 ,4'd0,2'd1,4'd9 ,4'd0,2'd0,4'd5}
  };

  task automatic drive(input logic rd, input logic wr, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic check(input logic [1:0] kind, input logic [3:0] mod, input logic [3:0] sub,
                       input logic [1:0] nib, input int req);
    logic [15:0] ep, ea, es;
    logic [3:0]  ei;
    logic        ew;
    ep = (kind == 2'd1) ? 16'(1) << mod : '0;
    ea = (kind == 2'd2) ? 16'(1) << mod : '0;
    es = (kind == 2'd3) ? 16'(1) << mod : '0;
    ei = (kind == 2'd3) ? sub : '0;
    ew = bus_wr && (kind != 2'd0);
    n_chk++;
    // R9 one-hot is implied by the exact comparison of all three vectors
    if (prim_stb !== ep || aux_stb !== ea || sub_stb !== es || sub_idx !== ei ||
        nib_idx !== nib || acc_wr !== ew) begin
      n_bad++;
      $display("FAIL R%0d: got prim=%h aux=%h sub=%h idx=%0d nib=%0d wr=%b exp prim=%h aux=%h sub=%h idx=%0d nib=%0d wr=%b",
               req, prim_stb, aux_stb, sub_stb, sub_idx, nib_idx, acc_wr, ep, ea, es, ei, nib, ew);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(2'd0, 4'd0, 4'd0, 2'd0, 1); // R1 quiet in reset
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rd, VEC[i].wr, VEC[i].addr, VEC[i].data);
      check(VEC[i].kind, VEC[i].mod, VEC[i].sub, VEC[i].nib, int'(VEC[i].req));
    end
    // R1: reset drops an armed switch and clears subport indexes
    drive(1'b0, 1'b1, 4'd15, 4'd2);
    check(2'd0, 4'd0, 4'd0, 2'd0, 3);
    @(negedge clk);
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    #1 check(2'd0, 4'd0, 4'd0, 2'd0, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 4'd2, 4'd0); check(2'd1, 4'd2, 4'd0, 2'd0, 1);
    drive(1'b1, 1'b0, 4'd0, 4'd0); check(2'd3, 4'd0, 4'd0, 2'd0, 1);
    drive(1'b0, 1'b1, 4'd0, 4'd0); check(2'd3, 4'd0, 4'd0, 2'd1, 7);
    drive(1'b1, 1'b0, 4'd1, 4'd0); check(2'd3, 4'd1, 4'd0, 2'd0, 1);
    // R4 then R6: arming module 1 twice in a row hits aux each time
    drive(1'b0, 1'b1, 4'd15, 4'd1); check(2'd0, 4'd0, 4'd0, 2'd0, 3);
    drive(1'b0, 1'b1, 4'd1, 4'd7);  check(2'd2, 4'd1, 4'd0, 2'd0, 4);
    drive(1'b0, 1'b1, 4'd15, 4'd1); check(2'd0, 4'd0, 4'd0, 2'd0, 3);
    drive(1'b1, 1'b0, 4'd1, 4'd0);  check(2'd2, 4'd1, 4'd0, 2'd1, 7);
    drive(1'b1, 1'b0, 4'd1, 4'd0);  check(2'd3, 4'd1, 4'd7, 2'd0, 6);
    drive(1'b0, 1'b0, 4'd0, 4'd0);  check(2'd0, 4'd0, 4'd0, 2'd0, 8);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule